// File: doc/BRIEF.md
# Host Bridge Control Register File with Indirect Configuration Port

This block is the register front end that a processor sees when it talks to a host-to-PCI bridge. It holds a small set of local control registers, a bank of twelve masked tuning registers, and an indirect path to the downstream bus. Software first loads a 32-bit target address into the configuration pointer. A word access to the configuration data port, or an access of one, two or four bytes to the I/O window, then becomes a single downstream request built from that pointer. The bridge core that carries the request onto the bus sits outside this block. It answers on a small valid/data response port.

Each processor access is offered with a valid/ready handshake and is answered exactly once on the response port. Accesses served locally answer on the cycle after acceptance. Accesses that go downstream answer on the cycle after the downstream response. The legality of each access is judged from its offset and size. An access that is not legal gets an error response, changes no state and returns zero data.

Top module: `bcr_top`

## Requirements
- R1: After reset the crash-vector register (offset 0x020) reads 0xFFFA0030. The fast-back-to-back register (0x05C), the configuration pointer (0x064) and all twelve bank registers read 0.
- R2: The bank holds twelve word registers at offsets 0x800 + 4*i, for i = 0 to 11. A write stores only the low K(i) bits of the data, where K = 1, 7, 7, 8, 7, 9, 32, 8, 30, 25, 22, 9 for i = 0 to 11. The other bits are stored as 0.
- R3: Reads of the bank force some bits to 0: bit 0 of 0x804, bits 2:0 of 0x81C, and bits 3, 5, 6, 7, 15 and 24 of 0x820.
- R4: The configuration pointer at 0x064 takes word accesses only and reads back all 32 written bits. Every downstream address derived from it uses the pointer with bits 1:0 cleared.
- R5: A word access to 0x068 issues one downstream configuration request (dn_req_io = 0, size code 2). Its address is the cleared pointer ORed with the access byte offset, and it carries the write data unchanged. A read returns the downstream response word.
- R6: An access to the I/O window 0x06C to 0x06F issues one downstream I/O request (dn_req_io = 1). Its address is the cleared pointer plus the byte offset, and it has the access size. Lanes are big-endian: a byte at offset k sits in bits [31-8k:24-8k], a halfword at offset 0 or 2 sits in bits [31:16] or [15:0], and a word fills all 32 bits. Read data returns right-justified.
- R7: A write to 0x05C keeps only bits 1:0.
- R8: A write to 0x020 sets the crash vector to 0xFFFA0030 ORed with data bits 16:13.
- R9: Size codes are 0 byte, 1 halfword, 2 word and 3 reserved. Bytes are legal at 0x06C to 0x06F, halfwords at 0x06C and 0x06E, and words only at the listed word-aligned register offsets. Any other access gets rsp_err = 1 and rsp_rdata = 0. It modifies no register and issues no downstream request.
- R10: A local or illegal access responds exactly one cycle after acceptance. While a downstream request is pending, req_ready is low and the request fields stay stable until dn_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access offered |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response strobe, one per access |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 32 | Read data, right-justified |
| dn_req_valid | output | 1 | Downstream request pending |
| dn_req_io | output | 1 | 1 = I/O space, 0 = configuration space |
| dn_req_write | output | 1 | Downstream write |
| dn_req_addr | output | 32 | Downstream address |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | 32 | Downstream lane-placed write data |
| dn_rsp_valid | input | 1 | Downstream completion |
| dn_rsp_rdata | input | 32 | Downstream read word |

## Verification
Each bank register is written with all ones and read back. This exposes every keep mask and every read-zero bit separately. The crash vector and fast-back-to-back registers are written with all ones and then zeros, which separates kept bits from fixed ones. The pointer is loaded with nonzero low bits, so a missing clear on the downstream address shows up at once. Byte, halfword and word window accesses at different offsets tell apart lane placement, offset addition and right-justified readback. Illegal sizes and offsets, including an illegal write to a live register, are followed by readback to show that no state changed and no request was issued.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam int BCR_AW = 12;
    localparam int BCR_DW = 32;
    localparam int BANK_N = 12;

    localparam logic [11:0] OFS_CRASH = 12'h020;
    localparam logic [11:0] OFS_FBB   = 12'h05C;
    localparam logic [11:0] OFS_CFGA  = 12'h064;
    localparam logic [11:0] OFS_CFGD  = 12'h068;
    localparam logic [11:0] OFS_IOWIN = 12'h06C;
    localparam logic [11:0] OFS_BANK  = 12'h800;

    localparam logic [31:0] CRASH_BASE  = 32'hFFFA0030;
    localparam logic [31:0] CRASH_FIELD = 32'h0001E000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3
    } bcr_size_e;

    typedef enum logic [2:0] {
        TG_NONE, TG_CRASH, TG_FBB, TG_CFGA, TG_CFGD, TG_IOWIN, TG_BANK
    } bcr_tgt_e;

    typedef struct packed {
        logic       legal;
        bcr_tgt_e   tgt;
        logic [3:0] bidx;
        logic [1:0] boff;
    } bcr_dec_t;

    function automatic int unsigned keep_width(int unsigned i);
        case (i)
            0: return 1;   1: return 7;   2: return 7;   3: return 8;
            4: return 7;   5: return 9;   6: return 32;  7: return 8;
            8: return 30;  9: return 25;  10: return 22; default: return 9;
        endcase
    endfunction

    function automatic logic [31:0] keep_mask(int unsigned i);
        int unsigned w;
        w = keep_width(i);
        if (w >= 32) return '1;
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic logic [31:0] rdz_mask(int unsigned i);
        case (i)
            1: return 32'h0000_0001;
            7: return 32'h0000_0007;
            8: return 32'h0100_80E8;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] lane_place(logic [31:0] d, logic [1:0] sz,
                                               logic [1:0] off);
        logic [4:0] sh;
        case (sz)
            SZ_BYTE: begin sh = {~off, 3'b000}; return {24'b0, d[7:0]} << sh; end
            SZ_HALF: begin sh = {~off[1], 4'b0000}; return {16'b0, d[15:0]} << sh; end
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] lane_pick(logic [31:0] w, logic [1:0] sz,
                                              logic [1:0] off);
        logic [4:0] sh;
        case (sz)
            SZ_BYTE: begin sh = {~off, 3'b000}; return (w >> sh) & 32'h0000_00FF; end
            SZ_HALF: begin sh = {~off[1], 4'b0000}; return (w >> sh) & 32'h0000_FFFF; end
            default: return w;
        endcase
    endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int AW = BCR_AW,
    parameter int NB = BANK_N
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output bcr_dec_t      dec
);
    localparam logic [AW-1:0] A_IO_LO   = AW'(OFS_IOWIN);
    localparam logic [AW-1:0] A_IO_HI   = AW'(OFS_IOWIN) + AW'(3);
    localparam logic [AW-1:0] A_BANK_LO = AW'(OFS_BANK);
    localparam logic [AW-1:0] A_BANK_HI = AW'(OFS_BANK) + AW'(4 * NB);

    logic [AW-1:0] bank_rel;
    assign bank_rel = addr - A_BANK_LO;

    always_comb begin
        dec      = '0;
        dec.tgt  = TG_NONE;
        dec.boff = addr[1:0];
        dec.bidx = bank_rel[5:2];
        if (addr >= A_IO_LO && addr <= A_IO_HI) begin
            dec.tgt = TG_IOWIN;
            case (size)
                SZ_BYTE: dec.legal = 1'b1;
                SZ_HALF: dec.legal = ~addr[0];
                SZ_WORD: dec.legal = (addr[1:0] == 2'b00);
                default: dec.legal = 1'b0;
            endcase
        end else if (size == SZ_WORD && addr[1:0] == 2'b00) begin
            dec.legal = 1'b1;
            if (addr == AW'(OFS_CRASH))      dec.tgt = TG_CRASH;
            else if (addr == AW'(OFS_FBB))   dec.tgt = TG_FBB;
            else if (addr == AW'(OFS_CFGA))  dec.tgt = TG_CFGA;
            else if (addr == AW'(OFS_CFGD))  dec.tgt = TG_CFGD;
            else if (addr >= A_BANK_LO && addr < A_BANK_HI) dec.tgt = TG_BANK;
            else dec.legal = 1'b0;
        end
    end
endmodule

// File: rtl/bcr_bank.sv
module bcr_bank
    import bcr_pkg::*;
#(
    parameter int NB = BANK_N,
    parameter int DW = BCR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    widx,
    input  logic [DW-1:0] wdata,
    input  logic [3:0]    ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NB];

    for (genvar g = 0; g < NB; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = DW'(keep_mask(g));
        always_ff @(posedge clk) begin
            if (rst)                          regs[g] <= '0;
            else if (we && widx == 4'(g))     regs[g] <= wdata & KEEP;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++)
            if (ridx == 4'(i)) rdata = regs[i] & ~DW'(rdz_mask(i));
    end

    // R3
    rdz_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata & DW'(rdz_mask(32'(ridx)))) == '0);
endmodule

// File: rtl/bcr_dnport.sv
module bcr_dnport
    import bcr_pkg::*;
#(
    parameter int DW = BCR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          l_io,
    input  logic          l_write,
    input  logic [31:0]   l_addr,
    input  logic [1:0]    l_size,
    input  logic [DW-1:0] l_wdata,
    output logic          dn_req_valid,
    output logic          dn_req_io,
    output logic          dn_req_write,
    output logic [31:0]   dn_req_addr,
    output logic [1:0]    dn_req_size,
    output logic [DW-1:0] dn_req_wdata,
    input  logic          dn_rsp_valid,
    output logic          done
);
    assign done = dn_req_valid && dn_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_req_valid <= 1'b0;
            dn_req_io    <= 1'b0;
            dn_req_write <= 1'b0;
            dn_req_addr  <= '0;
            dn_req_size  <= '0;
            dn_req_wdata <= '0;
        end else if (launch) begin
            dn_req_valid <= 1'b1;
            dn_req_io    <= l_io;
            dn_req_write <= l_write;
            dn_req_addr  <= l_addr;
            dn_req_size  <= l_size;
            dn_req_wdata <= l_wdata;
        end else if (done) begin
            dn_req_valid <= 1'b0;
        end
    end

    // R10
    dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req_valid && !dn_rsp_valid |=> dn_req_valid && $stable(dn_req_addr)
                                          && $stable(dn_req_wdata));
endmodule

// File: rtl/bcr_top.sv
module bcr_top
    import bcr_pkg::*;
#(
    parameter int AW = BCR_AW,
    parameter int NB = BANK_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [31:0]   rsp_rdata,
    output logic          dn_req_valid,
    output logic          dn_req_io,
    output logic          dn_req_write,
    output logic [31:0]   dn_req_addr,
    output logic [1:0]    dn_req_size,
    output logic [31:0]   dn_req_wdata,
    input  logic          dn_rsp_valid,
    input  logic [31:0]   dn_rsp_rdata
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e         st_q;
    bcr_dec_t    dec;
    logic        acc, is_dn, wr_ok, dn_done;
    logic [31:0] crash_q, cfga_q, bank_rd, local_rd, ptr_al;
    logic [1:0]  fbb_q;
    logic        pend_io, pend_wr;
    logic [1:0]  pend_sz, pend_off;

    bcr_decode #(.AW(AW), .NB(NB)) u_dec (.addr(req_addr), .size(req_size), .dec(dec));

    assign req_ready = (st_q == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign is_dn     = dec.legal && (dec.tgt == TG_CFGD || dec.tgt == TG_IOWIN);
    assign wr_ok     = acc && dec.legal && req_write;
    assign ptr_al    = {cfga_q[31:2], 2'b00};

    bcr_bank #(.NB(NB), .DW(32)) u_bank (
        .clk(clk), .rst(rst),
        .we(wr_ok && dec.tgt == TG_BANK), .widx(dec.bidx), .wdata(req_wdata),
        .ridx(dec.bidx), .rdata(bank_rd)
    );

    logic [31:0] l_addr, l_wdata;
    logic [1:0]  l_size;
    always_comb begin
        if (dec.tgt == TG_IOWIN) begin
            l_addr  = ptr_al + {30'b0, dec.boff};
            l_size  = req_size;
            l_wdata = lane_place(req_wdata, req_size, dec.boff);
        end else begin
            l_addr  = ptr_al | {30'b0, dec.boff};
            l_size  = SZ_WORD;
            l_wdata = req_wdata;
        end
    end

    bcr_dnport #(.DW(32)) u_dn (
        .clk(clk), .rst(rst), .launch(acc && is_dn),
        .l_io(dec.tgt == TG_IOWIN), .l_write(req_write), .l_addr(l_addr),
        .l_size(l_size), .l_wdata(l_wdata),
        .dn_req_valid(dn_req_valid), .dn_req_io(dn_req_io),
        .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr),
        .dn_req_size(dn_req_size), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .done(dn_done)
    );

    always_comb begin
        case (dec.tgt)
            TG_CRASH: local_rd = crash_q;
            TG_FBB:   local_rd = {30'b0, fbb_q};
            TG_CFGA:  local_rd = cfga_q;
            TG_BANK:  local_rd = bank_rd;
            default:  local_rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crash_q <= CRASH_BASE;
            fbb_q   <= '0;
            cfga_q  <= '0;
        end else if (wr_ok) begin
            if (dec.tgt == TG_CRASH) crash_q <= CRASH_BASE | (req_wdata & CRASH_FIELD);
            if (dec.tgt == TG_FBB)   fbb_q   <= req_wdata[1:0];
            if (dec.tgt == TG_CFGA)  cfga_q  <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            pend_io  <= 1'b0;
            pend_wr  <= 1'b0;
            pend_sz  <= '0;
            pend_off <= '0;
        end else if (acc && is_dn) begin
            st_q     <= ST_WAIT;
            pend_io  <= (dec.tgt == TG_IOWIN);
            pend_wr  <= req_write;
            pend_sz  <= req_size;
            pend_off <= dec.boff;
        end else if (dn_done) begin
            st_q <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            if (acc && !is_dn) begin
                rsp_valid <= 1'b1;
                rsp_err   <= ~dec.legal;
                rsp_rdata <= (dec.legal && !req_write) ? local_rd : '0;
            end else if (dn_done) begin
                rsp_valid <= 1'b1;
                if (!pend_wr)
                    rsp_rdata <= pend_io ? lane_pick(dn_rsp_rdata, pend_sz, pend_off)
                                         : dn_rsp_rdata;
            end
        end
    end

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_err |-> rsp_rdata == '0);
    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req_valid |-> !req_ready);
    // R8
    crash_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (crash_q & ~CRASH_FIELD) == CRASH_BASE);
    // R4
    cfg_align_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req_valid && !dn_req_io |-> dn_req_addr[1:0] == 2'b00);
    // R6
    io_base_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req_valid && dn_req_io |-> dn_req_addr[31:2] == cfga_q[31:2]);
endmodule

// File: tb/sim_bcr_top.sv
`timescale 1ns/1ps
module sim_bcr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_req_valid, dn_req_io, dn_req_write;
    logic [31:0] dn_req_addr, dn_req_wdata;
    logic [1:0]  dn_req_size;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic        cap_dn, cap_io, cap_wr;
    logic [31:0] cap_addr, cap_wd;
    logic [1:0]  cap_sz;

    always #4 clk = ~clk;

    bcr_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] dnv,
                          output logic [31:0] rd, output logic err);
        cap_dn = 0; rd = 'x; err = 1'bx;
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (rsp_valid) begin
            rd = rsp_rdata; err = rsp_err;
        end else if (dn_req_valid) begin
            cap_dn = 1; cap_io = dn_req_io; cap_wr = dn_req_write;
            cap_addr = dn_req_addr; cap_sz = dn_req_size; cap_wd = dn_req_wdata;
            chk("R10 ready low while pending", {31'b0, req_ready}, 32'd0);
            dn_rsp_valid = 1; dn_rsp_rdata = dnv;
            @(negedge clk);
            dn_rsp_valid = 0;
            chk("R10 response after downstream", {31'b0, rsp_valid}, 32'd1);
            rd = rsp_rdata; err = rsp_err;
        end else begin
            chk("R10 local response one cycle", 32'd0, 32'd1);
        end
    endtask

    function automatic logic [31:0] keep_of(int i);
        int w[12] = '{1, 7, 7, 8, 7, 9, 32, 8, 30, 25, 22, 9};
        return (w[i] == 32) ? 32'hFFFF_FFFF : ((32'd1 << w[i]) - 1);
    endfunction

    task automatic t_reset;
        logic [31:0] rd; logic e;
        access(0, 12'h020, 2, 0, 0, rd, e); chk("R1 crash reset", rd, 32'hFFFA0030);
        access(0, 12'h05C, 2, 0, 0, rd, e); chk("R1 fbb reset", rd, 0);
        access(0, 12'h064, 2, 0, 0, rd, e); chk("R1 pointer reset", rd, 0);
        access(0, 12'h818, 2, 0, 0, rd, e); chk("R1 bank reset", rd, 0);
    endtask

    task automatic t_bank;
        logic [31:0] rd, exp; logic e;
        for (int i = 0; i < 12; i++) begin
            access(1, 12'(12'h800 + 4 * i), 2, 32'hFFFF_FFFF, 0, rd, e);
            access(0, 12'(12'h800 + 4 * i), 2, 0, 0, rd, e);
            exp = keep_of(i);
            if (i == 1) exp &= ~32'h1;
            if (i == 7) exp &= ~32'h7;
            if (i == 8) exp &= ~32'h0100_80E8;
            chk($sformatf("R2 R3 bank %0d", i), rd, exp);
        end
        access(1, 12'h818, 2, 32'h1234_5678, 0, rd, e);
        access(0, 12'h818, 2, 0, 0, rd, e); chk("R2 full width pattern", rd, 32'h1234_5678);
    endtask

    task automatic t_local;
        logic [31:0] rd; logic e;
        access(1, 12'h05C, 2, 32'hFFFF_FFFF, 0, rd, e);
        access(0, 12'h05C, 2, 0, 0, rd, e); chk("R7 fbb keep", rd, 32'h3);
        access(1, 12'h020, 2, 32'hFFFF_FFFF, 0, rd, e);
        access(0, 12'h020, 2, 0, 0, rd, e); chk("R8 crash ones", rd, 32'hFFFBE030);
        access(1, 12'h020, 2, 32'h0000_A000, 0, rd, e);
        access(0, 12'h020, 2, 0, 0, rd, e); chk("R8 crash partial", rd, 32'hFFFAA030);
    endtask

    task automatic t_config;
        logic [31:0] rd; logic e;
        access(1, 12'h064, 2, 32'h8000_1237, 0, rd, e);
        access(0, 12'h064, 2, 0, 0, rd, e); chk("R4 pointer readback", rd, 32'h8000_1237);
        access(1, 12'h068, 2, 32'h0000_CAFE, 0, rd, e);
        chk("R5 cfg write issued", {31'b0, cap_dn}, 1);
        chk("R4 R5 cfg addr", cap_addr, 32'h8000_1234);
        chk("R5 cfg kind/dir/size", {29'b0, cap_io, cap_wr, cap_sz == 2'd2}, 32'b011);
        chk("R5 cfg wdata", cap_wd, 32'h0000_CAFE);
        access(0, 12'h068, 2, 0, 32'h1122_3344, rd, e);
        chk("R5 cfg read data", rd, 32'h1122_3344);
    endtask

    task automatic t_io;
        logic [31:0] rd; logic e;
        access(1, 12'h06D, 0, 32'h0000_00AB, 0, rd, e);
        chk("R6 byte write addr", cap_addr, 32'h8000_1235);
        chk("R6 byte write lanes", cap_wd, 32'h00AB_0000);
        chk("R6 io kind size", {29'b0, cap_io, cap_sz}, 32'b100);
        access(0, 12'h06F, 0, 0, 32'h1122_3344, rd, e);
        chk("R6 byte read off3", rd, 32'h44);
        chk("R6 byte read addr", cap_addr, 32'h8000_1237);
        access(0, 12'h06E, 1, 0, 32'h1122_3344, rd, e);
        chk("R6 half read off2", rd, 32'h3344);
        access(0, 12'h06C, 1, 0, 32'h1122_3344, rd, e);
        chk("R6 half read off0", rd, 32'h1122);
        access(1, 12'h06E, 1, 32'h0000_BEEF, 0, rd, e);
        chk("R6 half write lanes", cap_wd, 32'h0000_BEEF);
        access(1, 12'h06C, 2, 32'hDEAD_BEEF, 0, rd, e);
        chk("R6 word write", cap_wd, 32'hDEAD_BEEF);
        chk("R6 word addr", cap_addr, 32'h8000_1234);
    endtask

    task automatic t_illegal;
        logic [31:0] rd; logic e;
        logic [11:0] a[5] = '{12'h06D, 12'h064, 12'h066, 12'h900, 12'h020};
        logic [1:0]  s[5] = '{2'd1, 2'd0, 2'd2, 2'd2, 2'd3};
        for (int i = 0; i < 5; i++) begin
            access(0, a[i], s[i], 0, 32'hFFFF_FFFF, rd, e);
            chk($sformatf("R9 err %0d", i), {31'b0, e}, 1);
            chk($sformatf("R9 zero data %0d", i), rd, 0);
            chk($sformatf("R9 no downstream %0d", i), {31'b0, cap_dn}, 0);
        end
        access(1, 12'h020, 0, 32'hFFFF_FFFF, 0, rd, e);
        chk("R9 illegal write err", {31'b0, e}, 1);
        access(0, 12'h020, 2, 0, 0, rd, e); chk("R9 crash unchanged", rd, 32'hFFFAA030);
        access(1, 12'h064, 1, 32'h0, 0, rd, e);
        access(0, 12'h064, 2, 0, 0, rd, e); chk("R9 pointer unchanged", rd, 32'h8000_1237);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_bank();
        t_local();
        t_config();
        t_io();
        t_illegal();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule